// File: doc/BRIEF.md
# Hardware Cursor Overlay

This block draws a 64×64 two-plane hardware cursor over a raster. Software programs it through one indexed byte-write port. Through that port it sets the cursor position, selects a display mode, loads a background colour and a foreground colour, and fills a 1024-byte pattern memory. The video side supplies the current raster coordinate every cycle. One cycle later the block returns a per-pixel select (transparent, background, foreground or invert) and the 24-bit colour that goes with that select.

Each position register holds the screen coordinate plus 64. A cursor can therefore be placed partly off the top or left edge of the screen without using negative numbers. The pattern memory splits into two halves: the source plane comes first and the mask plane follows. Each half stores eight bytes per row, with the leftmost pixel of a byte in bit 7.

Colours load as byte triplets. A colour-index write selects the entry and resets the byte pointer, which is a three-state machine:
- `CP_RED` goes to `CP_GREEN` on a colour-data write.
- `CP_GREEN` goes to `CP_BLUE` on a colour-data write.
- `CP_BLUE` goes back to `CP_RED` on a colour-data write, and the entry number advances at the same time.
- Any state goes to `CP_RED` on a colour-index write.

Top module: `cursor_overlay`

## Requirements
- R1: After reset, `pix_sel` is 0 (transparent) and `pix_color` is 0.
- R2: Index 3 and index 4 set the biased X register: index 3 writes bits 7:0, and index 4 writes bits 11:8 from data bits 3:0 while its data bits 7:4 are ignored. Index 5 and index 6 set the biased Y register in the same way. A raster pixel (h,v) lies inside the cursor when both 0 ≤ h+64−X < 64 and 0 ≤ v+64−Y < 64, with the sums taken without wrap.
- R3: Index 0 is the control register, and its bits 1:0 select the mode. Mode 0 turns the cursor off, so every pixel is transparent.
- R4: Mode 3 (X11) decodes each pixel from its mask bit m and source bit s. When m=0 the pixel is transparent (select 0). When m=1 and s=0 it is background (select 1). When m=1 and s=1 it is foreground (select 2).
- R5: Mode 1 gives transparent for m=0, background for m=1 with s=0, and invert (select 3) for m=1 with s=1. Mode 2 gives transparent for m=0 with s=0, invert for m=0 with s=1, background for m=1 with s=0, and foreground for m=1 with s=1.
- R6: Writing index 7 selects colour entry 1 (background) or entry 2 (foreground). Each write to index 8 then loads red, green and blue in turn into bits 23:16, 15:8 and 7:0 of that entry.
- R7: After the blue byte is written, the colour pointer moves to the next entry modulo 4 and returns to red. Data written while the entry is 0 or 3 is dropped.
- R8: The pattern address is 10 bits. Control bits 3:2 set address bits 9:8. Index 1 sets address bits 7:0. Each write to index 2 stores a byte and then increments the full address, so bits 7:0 carry into bits 9:8 and address 1023 wraps to 0.
- R9: The source bit for cursor pixel (row r, column c) is at byte 8r + c/8, bit 7 − (c mod 8). The mask bit for the same pixel is at that byte plus 512.
- R10: `pix_sel` and `pix_color` are registered and reflect the raster coordinate presented one clock earlier.
- R11: `pix_color` equals the background colour when the select is 1 and the foreground colour when the select is 2. It is 0 when the select is 0 or 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register index |
| reg_wdata | input | 8 | Register write data |
| hcount | input | 12 | Current raster column |
| vcount | input | 12 | Current raster line |
| pix_sel | output | 2 | 0 transparent, 1 background, 2 foreground, 3 invert |
| pix_color | output | 24 | Selected colour, red in bits 23:16 |

## Verification
The bench sweeps the whole cursor window plus a two-pixel margin in X11 mode and compares every pixel with an arithmetic model of the bit layout. This catches a design that reverses the bit order, swaps the planes or is off by one at an edge of the window, because pixels would then light up wrongly or vanish. It also covers a cursor placed partly off-screen, and a high-position write that carries junk in its upper nibble; a design that took that nibble would move the cursor. Two further cases target the counters. A write to pattern address 1023 followed by one more write must reach byte 0, and a design that failed to wrap would corrupt a different row. A colour load aimed at entry 3 must be dropped and must carry into entry 0, so a design that aliased entry 3 onto the foreground would change the foreground colour. Finally, outputs are sampled just after new coordinates are applied, so a design with combinational outputs shows the new pixel one cycle too early.

// File: rtl/cursor_pkg.sv
package cursor_pkg;

    // Register indices seen on the write port
    typedef enum logic [3:0] {
        CR_CTRL     = 4'd0,
        CR_PAT_IDX  = 4'd1,
        CR_PAT_DATA = 4'd2,
        CR_XLO      = 4'd3,
        CR_XHI      = 4'd4,
        CR_YLO      = 4'd5,
        CR_YHI      = 4'd6,
        CR_COL_IDX  = 4'd7,
        CR_COL_DATA = 4'd8
    } creg_e;

    typedef enum logic [1:0] {
        MODE_OFF  = 2'd0,
        MODE_INV  = 2'd1,
        MODE_3COL = 2'd2,
        MODE_X11  = 2'd3
    } cmode_e;

    typedef enum logic [1:0] {
        PX_TRANS = 2'd0,
        PX_BG    = 2'd1,
        PX_FG    = 2'd2,
        PX_INV   = 2'd3
    } psel_e;

    // Colour byte pointer states
    typedef enum logic [1:0] {
        CP_RED   = 2'd0,
        CP_GREEN = 2'd1,
        CP_BLUE  = 2'd2
    } cptr_e;

endpackage

// File: rtl/cursor_regs.sv
module cursor_regs
    import cursor_pkg::*;
#(
    parameter int POS_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [3:0]       addr,
    input  logic [7:0]       wdata,
    output cmode_e           mode,
    output logic [POS_W-1:0] xpos,
    output logic [POS_W-1:0] ypos,
    output logic [23:0]      bg_col,
    output logic [23:0]      fg_col,
    output logic             pat_ld_hi,
    output logic             pat_ld_lo,
    output logic             pat_wr
);
    localparam int HI_W = POS_W - 8;

    cptr_e      cp_q, cp_d;
    logic [1:0] ent_q, ent_d;
    logic       col_idx_wr, col_dat_wr;

    assign col_idx_wr = wr && (addr == CR_COL_IDX);
    assign col_dat_wr = wr && (addr == CR_COL_DATA);
    assign pat_ld_hi  = wr && (addr == CR_CTRL);
    assign pat_ld_lo  = wr && (addr == CR_PAT_IDX);
    assign pat_wr     = wr && (addr == CR_PAT_DATA);

    // Colour pointer: state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cp_q  <= CP_RED;
            ent_q <= 2'd0;
        end else begin
            cp_q  <= cp_d;
            ent_q <= ent_d;
        end
    end

    // Colour pointer: next state
    always_comb begin
        cp_d  = cp_q;
        ent_d = ent_q;
        if (col_idx_wr) begin
            cp_d  = CP_RED;
            ent_d = wdata[1:0];
        end else if (col_dat_wr) begin
            unique case (cp_q)
                CP_RED:   cp_d = CP_GREEN;
                CP_GREEN: cp_d = CP_BLUE;
                CP_BLUE: begin
                    cp_d  = CP_RED;
                    ent_d = 2'(ent_q + 2'd1);
                end
                default:  cp_d = CP_RED;
            endcase
        end
    end

    // Colour pointer: outputs into the colour entries
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bg_col <= '0;
            fg_col <= '0;
        end else if (col_dat_wr) begin
            unique case (cp_q)
                CP_RED: begin
                    if (ent_q == 2'd1) bg_col[23:16] <= wdata;
                    if (ent_q == 2'd2) fg_col[23:16] <= wdata;
                end
                CP_GREEN: begin
                    if (ent_q == 2'd1) bg_col[15:8] <= wdata;
                    if (ent_q == 2'd2) fg_col[15:8] <= wdata;
                end
                CP_BLUE: begin
                    if (ent_q == 2'd1) bg_col[7:0] <= wdata;
                    if (ent_q == 2'd2) fg_col[7:0] <= wdata;
                end
                default: ;
            endcase
        end
    end

    // Mode and position registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= MODE_OFF;
            xpos <= '0;
            ypos <= '0;
        end else if (wr) begin
            unique case (addr)
                CR_CTRL: mode               <= cmode_e'(wdata[1:0]);
                CR_XLO:  xpos[7:0]          <= wdata;
                CR_XHI:  xpos[POS_W-1:8]    <= wdata[HI_W-1:0];
                CR_YLO:  ypos[7:0]          <= wdata;
                CR_YHI:  ypos[POS_W-1:8]    <= wdata[HI_W-1:0];
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/cursor_pattern_mem.sv
module cursor_pattern_mem #(
    parameter int MEM_BYTES = 1024
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         ld_hi,
    input  logic                         ld_lo,
    input  logic                         wr,
    input  logic [7:0]                   wdata,
    input  logic [$clog2(MEM_BYTES)-2:0] rd_idx,
    output logic [7:0]                   src_byte,
    output logic [7:0]                   mask_byte,
    output logic [$clog2(MEM_BYTES)-1:0] addr
);
    localparam int AW  = $clog2(MEM_BYTES);
    localparam int HIW = AW - 8;

    logic [7:0] mem [MEM_BYTES];

    // Load address: upper bits come from control bits above the mode field
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (ld_hi) begin
            addr[AW-1:8] <= wdata[2 +: HIW];
        end else if (ld_lo) begin
            addr[7:0] <= wdata;
        end else if (wr) begin
            addr <= AW'(addr + 1'b1);
        end
    end

    always_ff @(posedge clk) begin
        if (wr) mem[addr] <= wdata;
    end

    assign src_byte  = mem[{1'b0, rd_idx}];
    assign mask_byte = mem[{1'b1, rd_idx}];

endmodule

// File: rtl/cursor_pixel.sv
module cursor_pixel
    import cursor_pkg::*;
#(
    parameter int CUR   = 64,
    parameter int POS_W = 12
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [POS_W-1:0]                     hcount,
    input  logic [POS_W-1:0]                     vcount,
    input  logic [POS_W-1:0]                     xpos,
    input  logic [POS_W-1:0]                     ypos,
    input  cmode_e                               mode,
    input  logic [23:0]                          bg_col,
    input  logic [23:0]                          fg_col,
    input  logic [7:0]                           src_byte,
    input  logic [7:0]                           mask_byte,
    output logic [2*$clog2(CUR)-4:0]             rd_idx,
    output psel_e                                sel,
    output logic [23:0]                          color
);
    localparam int DW = POS_W + 1;
    localparam int CW = $clog2(CUR);

    logic [DW-1:0] dx, dy;
    logic          hit, s_bit, m_bit;
    logic [2:0]    bit_n;
    psel_e         sel_d;

    // Biased window test; a negative offset wraps to a large unsigned value
    assign dx  = {1'b0, hcount} + DW'(CUR) - {1'b0, xpos};
    assign dy  = {1'b0, vcount} + DW'(CUR) - {1'b0, ypos};
    assign hit = (dx < DW'(CUR)) && (dy < DW'(CUR));

    assign rd_idx = {dy[CW-1:0], dx[CW-1:3]};
    assign bit_n  = 3'd7 - dx[2:0];
    assign s_bit  = src_byte[bit_n];
    assign m_bit  = mask_byte[bit_n];

    always_comb begin
        sel_d = PX_TRANS;
        if (hit) begin
            unique case (mode)
                MODE_OFF:  sel_d = PX_TRANS;
                MODE_X11:  sel_d = m_bit ? (s_bit ? PX_FG : PX_BG) : PX_TRANS;
                MODE_INV:  sel_d = m_bit ? (s_bit ? PX_INV : PX_BG) : PX_TRANS;
                MODE_3COL: sel_d = m_bit ? (s_bit ? PX_FG : PX_BG)
                                         : (s_bit ? PX_INV : PX_TRANS);
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel   <= PX_TRANS;
            color <= '0;
        end else begin
            sel <= sel_d;
            unique case (sel_d)
                PX_BG:   color <= bg_col;
                PX_FG:   color <= fg_col;
                default: color <= '0;
            endcase
        end
    end

endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay
    import cursor_pkg::*;
#(
    parameter int CUR   = 64,
    parameter int POS_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [3:0]       reg_addr,
    input  logic [7:0]       reg_wdata,
    input  logic [POS_W-1:0] hcount,
    input  logic [POS_W-1:0] vcount,
    output logic [1:0]       pix_sel,
    output logic [23:0]      pix_color
);
    localparam int MEM_BYTES = 2 * CUR * (CUR / 8);
    localparam int AW        = $clog2(MEM_BYTES);

    cmode_e           cur_mode;
    logic [POS_W-1:0] xpos, ypos;
    logic [23:0]      bg_col, fg_col;
    logic             pat_ld_hi, pat_ld_lo, pat_wr;
    logic [AW-2:0]    rd_idx;
    logic [7:0]       src_byte, mask_byte;
    logic [AW-1:0]    pat_addr;
    psel_e            sel;

    cursor_regs #(.POS_W(POS_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .mode(cur_mode), .xpos(xpos), .ypos(ypos), .bg_col(bg_col), .fg_col(fg_col),
        .pat_ld_hi(pat_ld_hi), .pat_ld_lo(pat_ld_lo), .pat_wr(pat_wr)
    );

    cursor_pattern_mem #(.MEM_BYTES(MEM_BYTES)) u_mem (
        .clk(clk), .rst_n(rst_n), .ld_hi(pat_ld_hi), .ld_lo(pat_ld_lo), .wr(pat_wr),
        .wdata(reg_wdata), .rd_idx(rd_idx), .src_byte(src_byte), .mask_byte(mask_byte),
        .addr(pat_addr)
    );

    cursor_pixel #(.CUR(CUR), .POS_W(POS_W)) u_pix (
        .clk(clk), .rst_n(rst_n), .hcount(hcount), .vcount(vcount), .xpos(xpos),
        .ypos(ypos), .mode(cur_mode), .bg_col(bg_col), .fg_col(fg_col),
        .src_byte(src_byte), .mask_byte(mask_byte), .rd_idx(rd_idx),
        .sel(sel), .color(pix_color)
    );

    assign pix_sel = sel;

endmodule

// File: rtl/cursor_overlay_chk.sv
module cursor_overlay_chk #(
    parameter int AW = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_wr,
    input logic [3:0]    reg_addr,
    input logic [1:0]    mode,
    input logic [AW-1:0] pat_addr,
    input logic [23:0]   bg_col,
    input logic [23:0]   fg_col,
    input logic [1:0]    pix_sel,
    input logic [23:0]   pix_color
);
    // R3: a cursor switched off in the previous cycle shows nothing now
    a_r3_off_transparent: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode) == 2'd0) |-> (pix_sel == 2'd0));

    // R11: transparent and invert carry no colour
    a_r11_no_color: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_sel == 2'd0 || pix_sel == 2'd3) |-> (pix_color == 24'd0));

    // R11: background select carries the background entry
    a_r11_bg_color: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_sel == 2'd1) |-> (pix_color == $past(bg_col)));

    // R11: foreground select carries the foreground entry
    a_r11_fg_color: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_sel == 2'd2) |-> (pix_color == $past(fg_col)));

    // R8: each pattern data write steps the address by one, wrapping
    a_r8_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        $past(reg_wr && reg_addr == 4'd2) |-> (pat_addr == AW'($past(pat_addr) + 1'b1)));

    // R6: colour entries change only in response to a write
    a_r6_col_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(reg_wr) |-> ($stable(bg_col) && $stable(fg_col)));

endmodule

bind cursor_overlay cursor_overlay_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .mode(cur_mode), .pat_addr(pat_addr), .bg_col(bg_col), .fg_col(fg_col),
    .pix_sel(pix_sel), .pix_color(pix_color)
);

// File: tb/cursor_overlay_bench.sv
`timescale 1ns/1ps
module cursor_overlay_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_wr;
    logic [3:0]  reg_addr;
    logic [7:0]  reg_wdata;
    logic [11:0] hcount, vcount;
    logic [1:0]  pix_sel;
    logic [23:0] pix_color;

    int checks = 0;
    int errors = 0;

    // bench model of programmed state
    int          b_mode, b_x, b_y;
    logic [23:0] b_bg, b_fg;
    logic [7:0]  pat [1024];

    always #2.5 clk = ~clk;

    cursor_overlay u_cursor_overlay (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .hcount(hcount), .vcount(vcount),
        .pix_sel(pix_sel), .pix_color(pix_color)
    );

    function automatic logic [7:0] pat_fill(int i);
        if (i < 512) return 8'((i * 29) + (i >> 3) * 7);
        return 8'((i * 53) ^ (i >> 2));
    endfunction

    function automatic logic [1:0] exp_sel(int h, int v);
        int dx = h + 64 - b_x;
        int dy = v + 64 - b_y;
        int idx;
        logic s, m;
        if (b_mode == 0 || dx < 0 || dx > 63 || dy < 0 || dy > 63) return 2'd0;
        idx = dy * 8 + dx / 8;
        s = pat[idx][7 - dx % 8];
        m = pat[512 + idx][7 - dx % 8];
        case (b_mode)
            3: return m ? (s ? 2'd2 : 2'd1) : 2'd0;
            1: return m ? (s ? 2'd3 : 2'd1) : 2'd0;
            2: return m ? (s ? 2'd2 : 2'd1) : (s ? 2'd3 : 2'd0);
            default: return 2'd0;
        endcase
    endfunction

    function automatic logic [23:0] exp_col(logic [1:0] s);
        return (s == 2'd1) ? b_bg : (s == 2'd2) ? b_fg : 24'd0;
    endfunction

    task automatic chk(input string req, input logic [1:0] es, input logic [23:0] ec);
        checks++;
        if (pix_sel !== es || pix_color !== ec) begin
            errors++;
            $display("FAIL %s: sel=%0d color=%06h expected sel=%0d color=%06h",
                     req, pix_sel, pix_color, es, ec);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic set_mode(input int m);
        wr(4'd0, 8'(m));
        b_mode = m;
    endtask

    task automatic set_pos(input int x, input int y);
        b_x = (x + 64) & 12'hFFF;
        b_y = (y + 64) & 12'hFFF;
        wr(4'd3, 8'(b_x)); wr(4'd4, 8'(b_x >> 8));
        wr(4'd5, 8'(b_y)); wr(4'd6, 8'(b_y >> 8));
    endtask

    task automatic px(input string req, input int h, input int v);
        logic [1:0] es;
        @(negedge clk);
        hcount = 12'(h); vcount = 12'(v);
        @(negedge clk);
        es = exp_sel(h, v);
        chk(req, es, exp_col(es));
    endtask

    task automatic sweep(input string req, input int h0, input int h1, input int v0, input int v1);
        for (int v = v0; v <= v1; v++)
            for (int h = h0; h <= h1; h++)
                px(req, h, v);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [1:0] es_prev;
        rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
        hcount = '0; vcount = '0;
        b_mode = 0; b_x = 0; b_y = 0; b_bg = '0; b_fg = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset", 2'd0, 24'd0);

        // R6 R7: one index write, six data bytes fill background then foreground
        wr(4'd7, 8'd1);
        wr(4'd8, 8'h11); wr(4'd8, 8'h22); wr(4'd8, 8'h33);
        wr(4'd8, 8'h44); wr(4'd8, 8'h55); wr(4'd8, 8'h66);
        b_bg = 24'h112233; b_fg = 24'h445566;

        // R8: full pattern load from address 0, carrying through 255->256
        wr(4'd0, 8'h00);
        wr(4'd1, 8'h00);
        for (int i = 0; i < 1024; i++) begin
            pat[i] = pat_fill(i);
            wr(4'd2, pat[i]);
        end

        // R3: cursor off over its own window
        set_pos(100, 50);
        sweep("R3 off", 98, 110, 48, 52);

        // R2 R4 R9 R11: full window plus margin in X11 mode
        set_mode(3);
        sweep("R2 R4 R9 R11 x11", 98, 165, 48, 115);

        // R5: the other two display modes
        set_mode(1);
        sweep("R5 invert mode", 98, 165, 48, 70);
        set_mode(2);
        sweep("R5 three-colour mode", 98, 165, 90, 115);

        // R10: outputs lag coordinates by one cycle
        set_mode(3);
        @(negedge clk);
        hcount = 12'd100; vcount = 12'd50;
        es_prev = exp_sel(100, 50);
        for (int k = 1; k < 64; k++) begin
            @(negedge clk);
            hcount = 12'(100 + k); vcount = 12'(50 + (k % 7));
            #1;
            chk("R10 latency", es_prev, exp_col(es_prev));
            es_prev = exp_sel(100 + k, 50 + (k % 7));
        end

        // R7: entry 3 is dropped and carries into entry 0, also dropped
        wr(4'd7, 8'd3);
        for (int k = 0; k < 6; k++) wr(4'd8, 8'hE0 + 8'(k));
        // R7: foreground load runs on into entry 3, which is dropped
        wr(4'd7, 8'd2);
        wr(4'd8, 8'hAA); wr(4'd8, 8'hBB); wr(4'd8, 8'hCC);
        wr(4'd8, 8'h99); wr(4'd8, 8'h98); wr(4'd8, 8'h97);
        b_fg = 24'hAABBCC;
        sweep("R6 R7 colour entries", 98, 165, 50, 53);

        // R2: cursor partly off the top-left corner
        set_pos(-10, -5);
        sweep("R2 off-screen", 0, 56, 0, 3);
        sweep("R2 off-screen bottom", 0, 56, 56, 59);

        // R2: upper nibble of the high position writes is ignored
        wr(4'd3, 8'h20); wr(4'd4, 8'hF1);
        wr(4'd5, 8'h80); wr(4'd6, 8'hA0);
        b_x = 12'h120; b_y = 12'h080;
        sweep("R2 high nibble", 222, 290, 62, 66);

        // R8: address 1023 then wrap to 0
        wr(4'd0, 8'h0C); b_mode = 0;
        wr(4'd1, 8'hFF);
        wr(4'd2, 8'h5A); pat[1023] = 8'h5A;
        wr(4'd2, 8'hC3); pat[0] = 8'hC3;
        set_mode(3);
        set_pos(100, 50);
        sweep("R8 wrap row 0", 98, 165, 50, 50);
        sweep("R8 wrap row 63", 98, 165, 113, 113);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule